// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small searchable store of eight 16-bit words, and each word has its own valid flag. The host loads a key register and a mask register, then issues a search. Every valid word is compared with the key at the same time. Only the bit positions selected by the mask are compared. The result is a per-word hit vector held in a match register. Hits are then taken out one at a time through a valid/ready output stream, lowest word index first.

New words come from the key register. A write fills the lowest free slot. When every slot is occupied, the write replaces the slot named by a replacement pointer. That pointer walks from slot 0 to slot 7 and wraps, so the oldest entry is replaced first. A single clear command empties the store at once.

The readout stream follows the usual valid/ready rules. `out_valid` is high while any match bit remains. A transfer happens on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, `out_word` and `out_idx` hold their values. The only exception is a search, write or clear, which changes the match register itself.

Top module: `masked_cam`

## Requirements
- R1: After reset every word is invalid. `match_vec` is 0, `any_hit` is 0, `out_valid` is 0, `none_left` is 1, and the mask register is 0.
- R2: `key_load` and `mask_load` each capture their input into the key or mask register on the clock edge. Both registers may load in the same cycle.
- R3: A search (`search_go`) compares each word with the key register. The comparison uses only the bit positions where the mask register holds 1; positions with mask 0 are don't-care. On the next edge, bit i of `match_vec` is 1 exactly when word i matches, and `any_hit` is the OR of those bits.
- R4: An invalid word never matches, whatever the key and mask are. With mask 0, a search returns exactly the valid-word vector.
- R5: While `out_valid` is high, `out_idx` is the lowest set bit of `match_vec` and `out_word` is the content of that word. A handshake clears that match bit on the edge. Without a handshake, both outputs hold.
- R6: `none_left` is 1 exactly when `match_vec` is all zero.
- R7: A search replaces the whole match register, which cancels any readout in progress. When a search and a handshake happen in the same cycle, the search wins.
- R8: A write (`write_go`) stores the key register into the lowest-indexed invalid word and marks that word valid. The new content is searchable from the next cycle.
- R9: When all words are valid, a write replaces the word at the replacement pointer and then advances the pointer by one, wrapping from 7 to 0. The pointer starts at 0 and does not move on writes into free words.
- R10: `clear_all` invalidates every word and zeroes the match register, `any_hit` and the replacement pointer. It takes priority over a write or a search in the same cycle.
- R11: A search issued in the same cycle as a write sees the contents from before the write. The write also clears the match bit of the slot it stores into.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load key register from key_in |
| key_in | input | 16 | Key value |
| mask_load | input | 1 | Load mask register from mask_in |
| mask_in | input | 16 | Mask value, 1 = compare this bit |
| search_go | input | 1 | Start a parallel search |
| write_go | input | 1 | Store key register into the array |
| clear_all | input | 1 | Invalidate every word |
| match_vec | output | 8 | Match register, bit i = word i |
| any_hit | output | 1 | Last search found at least one word |
| none_left | output | 1 | Match register is empty |
| out_valid | output | 1 | A match is offered on the stream |
| out_ready | input | 1 | Consumer accepts the offered match |
| out_word | output | 16 | Content of the offered word |
| out_idx | output | 3 | Index of the offered word |

## Verification
Search results, stored contents, cleared state and each handshake pop all become visible at the first clock edge after the command. The bench drives commands just after a falling edge and samples at the following falling edge, one edge later. The stream outputs are combinational from the match register and the array, so the bench reads them in that same sampled window. Stored contents and valid flags are observed only through later searches, using mask 0 for the valid vector and a full mask for exact placement.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // isolate the lowest set bit of a vector of up to 64 bits
  function automatic logic [63:0] isolate_low(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction
endpackage

// File: rtl/cam_array.sv
module cam_array #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic [WORDS-1:0] wr_onehot,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] mask,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [WORDS-1:0] valid,
  output logic [WORDS-1:0] hits,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] data_q [WORDS];
  logic [WORDS-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (clear_all) valid_q <= '0;
    else if (wr_en) valid_q <= valid_q | wr_onehot;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && !clear_all && wr_onehot[g]) data_q[g] <= key;
    end
    assign hits[g] = valid_q[g] && (((data_q[g] ^ key) & mask) == '0);
  end

  assign valid   = valid_q;
  assign rd_word = data_q[rd_idx];

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (valid == '0));
endmodule

// File: rtl/cam_alloc.sv
module cam_alloc #(
  parameter int WORDS = 8,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic [WORDS-1:0] valid,
  output logic [WORDS-1:0] wr_onehot,
  output logic             full
);
  logic [IDXW-1:0]  ptr_q;
  logic [WORDS-1:0] free_pick;

  assign full      = &valid;
  assign free_pick = WORDS'(cam_pkg::isolate_low(64'(~valid)));
  assign wr_onehot = full ? (WORDS'(1) << ptr_q) : free_pick;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) ptr_q <= '0;
    else if (wr_en && full) begin
      if (ptr_q == IDXW'(WORDS-1)) ptr_q <= '0;
      else ptr_q <= ptr_q + 1'b1;
    end
  end

  // R8: a write into a non-full array never targets a valid slot
  p_free_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full) |-> ((wr_onehot & valid) == '0));
  // R9: exactly one slot is written
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(wr_onehot));
endmodule

// File: rtl/cam_readout.sv
module cam_readout #(
  parameter int WORDS = 8,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             search,
  input  logic [WORDS-1:0] hits,
  input  logic             pop,
  input  logic             wr_en,
  input  logic [WORDS-1:0] wr_onehot,
  output logic [WORDS-1:0] match_q,
  output logic             any_hit_q,
  output logic             nonempty,
  output logic [IDXW-1:0]  pick_idx
);
  logic [WORDS-1:0] pick, match_d;

  assign pick     = WORDS'(cam_pkg::isolate_low(64'(match_q)));
  assign nonempty = |match_q;

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < WORDS; i++) if (pick[i]) pick_idx = IDXW'(i);
  end

  always_comb begin
    match_d = match_q;
    if (search) match_d = hits;
    else if (pop) match_d = match_q & ~pick;
    if (wr_en) match_d = match_d & ~wr_onehot;
    if (clear_all) match_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q   <= '0;
      any_hit_q <= 1'b0;
    end else begin
      match_q <= match_d;
      if (clear_all) any_hit_q <= 1'b0;
      else if (search) any_hit_q <= |hits;
    end
  end

  // R7: a plain search loads the compare result, discarding old state
  p_search_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (search && !wr_en && !clear_all) |=> (match_q == $past(hits)));
endmodule

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             mask_load,
  input  logic [WIDTH-1:0] mask_in,
  input  logic             search_go,
  input  logic             write_go,
  input  logic             clear_all,
  output logic [WORDS-1:0] match_vec,
  output logic             any_hit,
  output logic             none_left,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_word,
  output logic [IDXW-1:0]  out_idx
);
  logic [WIDTH-1:0] key_q, mask_q;
  logic [WORDS-1:0] valid, hits, wr_onehot;
  logic             full, nonempty, pop, wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      mask_q <= '0;
    end else begin
      if (key_load)  key_q  <= key_in;
      if (mask_load) mask_q <= mask_in;
    end
  end

  assign wr_en = write_go && !clear_all;
  assign pop   = nonempty && out_ready;

  cam_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .wr_en(wr_en),
    .wr_onehot(wr_onehot), .key(key_q), .mask(mask_q), .rd_idx(out_idx),
    .valid(valid), .hits(hits), .rd_word(out_word));

  cam_alloc #(.WORDS(WORDS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .wr_en(wr_en),
    .valid(valid), .wr_onehot(wr_onehot), .full(full));

  cam_readout #(.WORDS(WORDS)) u_read (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .search(search_go),
    .hits(hits), .pop(pop), .wr_en(wr_en), .wr_onehot(wr_onehot),
    .match_q(match_vec), .any_hit_q(any_hit), .nonempty(nonempty),
    .pick_idx(out_idx));

  assign out_valid = nonempty;
  assign none_left = !nonempty;

  // R4: the match register never names an invalid word
  p_match_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_vec & ~valid) == '0));
  // R3: after a plain search the hit flag agrees with the stream
  p_hit_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (search_go && !write_go && !clear_all) |=> (any_hit == out_valid));
  // R5: one handshake removes exactly one match
  p_pop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !search_go && !write_go && !clear_all) |=>
      ($countones(match_vec) == $past($countones(match_vec)) - 1));
  // R5: back-pressure holds the offered word
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !search_go && !write_go && !clear_all) |=>
      ($stable(out_idx) && $stable(out_word)));
  // R9: a full array stays full across a write
  p_full_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> full);
endmodule

// File: tb/tb_masked_cam.sv
`timescale 1ns/1ps
module tb_masked_cam;
  logic clk = 0, rst_n = 0;
  logic key_load = 0, mask_load = 0, search_go = 0, write_go = 0, clear_all = 0;
  logic out_ready = 0;
  logic [15:0] key_in = '0, mask_in = '0, out_word;
  logic [7:0] match_vec;
  logic any_hit, none_left, out_valid;
  logic [2:0] out_idx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  masked_cam dut (.clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .mask_load(mask_load), .mask_in(mask_in), .search_go(search_go),
    .write_go(write_go), .clear_all(clear_all), .match_vec(match_vec),
    .any_hit(any_hit), .none_left(none_left), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_idx(out_idx));

  // {key, mask, expected match}; contents: 0:A5C3 1:1234 2:A000 3:FFFF 4:1299 5:0000 6:A5C3, 7 invalid
  localparam logic [39:0] VEC [7] = '{
    {16'hA5C3, 16'hFFFF, 8'h41},
    {16'hA000, 16'hF000, 8'h45},
    {16'h1200, 16'hFF00, 8'h12},
    {16'h0000, 16'hFFFF, 8'h20},
    {16'h5A5A, 16'h0000, 8'h7F},
    {16'h0001, 16'h0001, 8'h59},
    {16'hBEEF, 16'hFFFF, 8'h00}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] k, input logic [15:0] m);
    key_in = k; mask_in = m; key_load = 1; mask_load = 1;
    tick();
    key_load = 0; mask_load = 0;
  endtask

  task automatic search(input logic [15:0] k, input logic [15:0] m);
    load(k, m);
    search_go = 1;
    tick();
    search_go = 0;
  endtask

  task automatic write_word(input logic [15:0] v);
    key_in = v; key_load = 1;
    tick();
    key_load = 0; write_go = 1;
    tick();
    write_go = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    chk("R1 match_vec", 32'(match_vec), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 none_left", 32'(none_left), 1);
    chk("R1 any_hit", 32'(any_hit), 0);
    search_go = 1; tick(); search_go = 0;  // mask reset 0, all invalid
    chk("R1 R4 empty search", 32'(match_vec), 0);

    write_word(16'hA5C3); write_word(16'h1234); write_word(16'hA000);
    write_word(16'hFFFF); write_word(16'h1299); write_word(16'h0000);
    write_word(16'hA5C3);

    // R2 R3 R4 vector walk
    foreach (VEC[i]) begin
      search(VEC[i][39:24], VEC[i][23:8]);
      chk($sformatf("R3 vec%0d match", i), 32'(match_vec), 32'(VEC[i][7:0]));
      chk($sformatf("R6 vec%0d none_left", i), 32'(none_left), 32'(VEC[i][7:0] == 0));
      chk($sformatf("R3 vec%0d any_hit", i), 32'(any_hit), 32'(VEC[i][7:0] != 0));
    end

    // R5 readout with back-pressure
    search(16'hA000, 16'hF000);
    chk("R5 first idx", 32'(out_idx), 0);
    chk("R5 first word", 32'(out_word), 32'hA5C3);
    tick(); tick();
    chk("R5 hold idx", 32'(out_idx), 0);
    out_ready = 1; tick(); out_ready = 0;
    chk("R5 second idx", 32'(out_idx), 2);
    chk("R5 second word", 32'(out_word), 32'hA000);
    out_ready = 1; tick();
    chk("R5 third idx", 32'(out_idx), 6);
    chk("R5 third word", 32'(out_word), 32'hA5C3);
    tick(); out_ready = 0;
    chk("R6 drained none_left", 32'(none_left), 1);
    chk("R5 drained valid", 32'(out_valid), 0);

    // R7 new search cancels readout; search beats pop
    search(16'hA000, 16'hF000);
    out_ready = 1; tick(); out_ready = 0;
    search(16'h1200, 16'hFF00);
    chk("R7 replaced match", 32'(match_vec), 32'h12);
    chk("R7 replaced idx", 32'(out_idx), 1);
    load(16'hFFFF, 16'hFFFF);
    search_go = 1; out_ready = 1; tick(); search_go = 0; out_ready = 0;
    chk("R7 search over pop", 32'(match_vec), 32'h08);

    // R8 lowest free slot
    write_word(16'h4242);
    search(16'h4242, 16'hFFFF);
    chk("R8 word7 placed", 32'(match_vec), 32'h80);
    search(16'h0000, 16'h0000);
    chk("R8 all valid", 32'(match_vec), 32'hFF);

    // R9 FIFO replacement with wrap
    for (int i = 0; i < 9; i++) write_word(16'hC000 + 16'(i));
    search(16'hC008, 16'hFFFF);
    chk("R9 wrap to word0", 32'(match_vec), 32'h01);
    search(16'hC007, 16'hFFFF);
    chk("R9 word7 replaced", 32'(match_vec), 32'h80);
    search(16'hC000, 16'hFFFF);
    chk("R9 oldest gone", 32'(match_vec), 32'h00);
    search(16'hC001, 16'hFFFF);
    chk("R9 first round word1", 32'(match_vec), 32'h02);

    // R11 write and search together (pointer now at 1)
    load(16'h7777, 16'h0000);
    search_go = 1; write_go = 1; tick(); search_go = 0; write_go = 0;
    chk("R11 written slot bit cleared", 32'(match_vec), 32'hFD);
    load(16'h8888, 16'hFFFF);
    search_go = 1; write_go = 1; tick(); search_go = 0; write_go = 0;
    chk("R11 old contents seen", 32'(match_vec), 32'h00);
    search(16'h8888, 16'hFFFF);
    chk("R11 stored at slot2", 32'(match_vec), 32'h04);

    // R10 clear wins over write, resets pointer
    search(16'h0000, 16'h0000);
    load(16'h9999, 16'h0000);
    clear_all = 1; write_go = 1; tick(); clear_all = 0; write_go = 0;
    chk("R10 match cleared", 32'(match_vec), 0);
    chk("R10 any_hit cleared", 32'(any_hit), 0);
    search_go = 1; tick(); search_go = 0;
    chk("R10 all invalid", 32'(match_vec), 0);
    for (int i = 0; i < 8; i++) write_word(16'hD000 + 16'(i));
    write_word(16'hE000);
    search(16'hE000, 16'hFFFF);
    chk("R10 pointer restarted", 32'(match_vec), 32'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule